// File: doc/BRIEF.md
# Multi-Channel Violation Counter Bank

The block keeps fourteen independent 16-bit event counters, one per line channel. Each counter advances by one on every clock cycle in which its channel's violation strobe is high, and it stops at 0xFFFF instead of wrapping. The live counts cannot be read directly. Software first copies them into per-channel holding registers, either for the whole bank or for one chosen channel, and then reads the chosen holding register one byte at a time through a small synchronous register port.

Three registers sit behind a 2-bit address. The control register holds the snapshot, clear and byte-select bits. The channel register names the channel that the per-channel operations and the readout use. The count window returns one byte of that channel's holding register. A clear bit only takes effect once software has held it at 1 for a parameterised number of cycles, which stands in for a minimum pulse width in time. Software then writes the bit back to 0.

Top module: `viol_bank`

## Requirements
- R1: After reset the control register (address 0), the channel register (address 1) and the count window (address 2) all read 0x00.
- R2: Each counter adds exactly one per clock cycle in which its own strobe is high, independently of the other channels.
- R3: A counter that has reached 0xFFFF stays at 0xFFFF while its strobe continues.
- R4: A 0-to-1 change of control bit 3 copies all live counts into their holding registers once. Keeping the bit at 1 takes no further copy, and a holding register keeps its value until the next copy of that channel.
- R5: A 0-to-1 change of control bit 1 copies only the live count of the channel held in channel register bits [3:0].
- R6: Reading address 2 returns holding bits [7:0] of the selected channel when control bit 2 is 0, and bits [15:8] when it is 1.
- R7: Control bit 4 clears all counters to 0x0000 once it has been high for CLR_MIN_CYC consecutive cycles, and keeps them clear while it stays high. A shorter pulse clears nothing.
- R8: Control bit 0, under the same hold rule, clears only the counter of the selected channel.
- R9: In a cycle where a channel is both cleared and strobed, the clear wins and the counter stays 0x0000.
- R10: Channel values 14 and 15 select nothing. The count window reads 0x00, and per-channel copy and clear leave every channel unchanged.
- R11: Control bits 7:5 read back as written. The channel register reads back bits [3:0] with bits [7:4] as 0, address 3 reads 0x00, and writes to addresses 2 and 3 are ignored.
- R12: Reading has no side effect on counters or holding registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address: 0 control, 1 channel, 2 count window, 3 unused |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| viol_strb | input | NUM_CH | Per-channel violation strobes, one count per high cycle |

## Verification
The hardest state to reach is a saturated counter. It takes 65,535 strobes before the ceiling matters, so the bench holds one channel's strobe high for more than 65,536 cycles and then takes a snapshot. A second hard case is a clear that competes with a strobe. Here the bench keeps a strobe high during the whole clear hold window and drops both in the same cycle, so the count must stay zero. The rising-edge rule for snapshots is probed by rewriting the update bit at 1 while counts move, then checking that the holding register still shows the first copy.

// File: rtl/viol_pkg.sv
package viol_pkg;
  localparam int DEF_NUM_CH = 14;
  localparam int DEF_CNT_W  = 16;
  localparam int SEL_W      = 4;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_CHAN = 2'd1,
    RA_CNT  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  localparam int B_CLR_ONE = 0;
  localparam int B_UPD_ONE = 1;
  localparam int B_BYTE_HI = 2;
  localparam int B_UPD_ALL = 3;
  localparam int B_CLR_ALL = 4;
endpackage

// File: rtl/viol_hold.sv
module viol_hold #(
  parameter int HOLD_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic fire_o
);
  localparam int HCW = $clog2(HOLD_CYC + 1);
  localparam logic [HCW-1:0] HMAX = HCW'(HOLD_CYC);

  logic [HCW-1:0] hc_q, hc_d;

  always_comb begin
    hc_d = hc_q;
    if (!lvl_i)           hc_d = '0;
    else if (hc_q != HMAX) hc_d = hc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc_q <= '0;
    else        hc_q <= hc_d;
  end

  assign fire_o = lvl_i && (hc_q == HMAX);

  AST_FIRE_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |-> $past(lvl_i)); // R7
endmodule

// File: rtl/viol_ctrl.sv
module viol_ctrl
  import viol_pkg::*;
#(
  parameter int CLR_MIN_CYC = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [7:0]       ctl_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             clr_all_o,
  output logic             clr_one_o,
  output logic             snap_all_o,
  output logic             snap_one_o
);
  logic [7:0]       ctl_q, ctl_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [1:0]       upd_prev_q, upd_prev_d;

  always_comb begin
    ctl_d      = ctl_q;
    sel_d      = sel_q;
    upd_prev_d = {ctl_q[B_UPD_ALL], ctl_q[B_UPD_ONE]};
    if (wr_en && wr_addr == RA_CTRL) ctl_d = wr_data;
    if (wr_en && wr_addr == RA_CHAN) sel_d = wr_data[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      sel_q      <= '0;
      upd_prev_q <= '0;
    end else begin
      ctl_q      <= ctl_d;
      sel_q      <= sel_d;
      upd_prev_q <= upd_prev_d;
    end
  end

  assign snap_all_o = ctl_q[B_UPD_ALL] & ~upd_prev_q[1];
  assign snap_one_o = ctl_q[B_UPD_ONE] & ~upd_prev_q[0];
  assign ctl_o      = ctl_q;
  assign sel_o      = sel_q;

  viol_hold #(.HOLD_CYC(CLR_MIN_CYC)) u_hold_all (
    .clk(clk), .rst_n(rst_n), .lvl_i(ctl_q[B_CLR_ALL]), .fire_o(clr_all_o));
  viol_hold #(.HOLD_CYC(CLR_MIN_CYC)) u_hold_one (
    .clk(clk), .rst_n(rst_n), .lvl_i(ctl_q[B_CLR_ONE]), .fire_o(clr_one_o));

  AST_SNAP_ALL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_all_o |=> !snap_all_o); // R4
  AST_SNAP_ONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    snap_one_o |=> !snap_one_o); // R5
  AST_CLR_ALL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_o |-> ctl_q[B_CLR_ALL]); // R7
endmodule

// File: rtl/viol_chan.sv
module viol_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strb_i,
  input  logic             clr_i,
  input  logic             snap_i,
  output logic [CNT_W-1:0] hold_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] hold_q, hold_d;

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    if (clr_i)                        cnt_d = '0;
    else if (strb_i && cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
    if (snap_i)                       hold_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && strb_i && cnt_q != CMAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && cnt_q == CMAX) |=> cnt_q == CMAX); // R3
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0); // R9
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_i |=> $stable(hold_q)); // R4
  AST_HOLD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> hold_q == $past(cnt_q)); // R5
endmodule

// File: rtl/viol_bank.sv
module viol_bank
  import viol_pkg::*;
#(
  parameter int NUM_CH      = DEF_NUM_CH,
  parameter int CNT_W       = DEF_CNT_W,
  parameter int CLR_MIN_CYC = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [NUM_CH-1:0] viol_strb
);
  logic             rs_meta_q, rs_q;
  logic [7:0]       ctl;
  logic [SEL_W-1:0] sel;
  logic             clr_all, clr_one, snap_all, snap_one;
  logic [NUM_CH-1:0] clr_vec, snap_vec;
  logic [CNT_W-1:0] hold [NUM_CH];
  logic [CNT_W-1:0] sel_hold;
  logic             sel_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  viol_ctrl #(.CLR_MIN_CYC(CLR_MIN_CYC)) u_ctrl (
    .clk(clk), .rst_n(rs_q), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .ctl_o(ctl), .sel_o(sel),
    .clr_all_o(clr_all), .clr_one_o(clr_one),
    .snap_all_o(snap_all), .snap_one_o(snap_one));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign clr_vec[g]  = clr_all  | (clr_one  && sel == SEL_W'(g));
    assign snap_vec[g] = snap_all | (snap_one && sel == SEL_W'(g));
    viol_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rs_q), .strb_i(viol_strb[g]), .clr_i(clr_vec[g]),
      .snap_i(snap_vec[g]), .hold_o(hold[g]));
  end

  always_comb begin
    sel_hold = '0;
    sel_ok   = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (sel == SEL_W'(i)) begin
        sel_hold = hold[i];
        sel_ok   = 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      RA_CTRL: reg_rdata = ctl;
      RA_CHAN: reg_rdata = 8'(sel);
      RA_CNT:  if (sel_ok) reg_rdata = ctl[B_BYTE_HI] ? sel_hold[15:8] : sel_hold[7:0];
      default: reg_rdata = 8'h00;
    endcase
  end

  AST_NOCH_READS_ZERO: assert property (@(posedge clk) disable iff (!rs_q)
    (reg_addr == RA_CNT && sel >= SEL_W'(NUM_CH)) |-> reg_rdata == 8'h00); // R10
  AST_NOCH_NO_TARGET: assert property (@(posedge clk) disable iff (!rs_q)
    (sel >= SEL_W'(NUM_CH) && !clr_all && !snap_all) |-> (clr_vec == '0 && snap_vec == '0)); // R10
endmodule

// File: tb/sim_viol_bank.sv
module sim_viol_bank;
  localparam int NCH = 14;
  localparam int CLR = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [NCH-1:0] viol = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  viol_bank #(.NUM_CH(NCH), .CNT_W(16), .CLR_MIN_CYC(CLR)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .viol_strb(viol));

  // {channel, strobe cycles, expected count}
  localparam logic [31:0] VEC [6] = '{
    {4'd0,  12'd1,    16'h0001},
    {4'd3,  12'd255,  16'h00FF},
    {4'd7,  12'd256,  16'h0100},
    {4'd9,  12'd300,  16'h012C},
    {4'd12, 12'd513,  16'h0201},
    {4'd13, 12'd1000, 16'h03E8}
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #2 v = reg_rdata;
  endtask

  task automatic strobe(input int c, input int n);
    @(negedge clk);
    viol[c] = 1'b1;
    repeat (n) @(negedge clk);
    viol[c] = 1'b0;
  endtask

  task automatic snap_ch(input int c);
    wr(2'd1, 8'(c));
    wr(2'd0, 8'h02);
    wr(2'd0, 8'h00);
  endtask

  task automatic read16(input int c, output logic [15:0] v);
    logic [7:0] lo, hi;
    wr(2'd1, 8'(c));
    wr(2'd0, 8'h00);
    rd(2'd2, lo);
    wr(2'd0, 8'h04);
    rd(2'd2, hi);
    wr(2'd0, 8'h00);
    v = {hi, lo};
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    rd(2'd0, b); chk("R1 ctrl", 16'(b), 16'h00);
    rd(2'd1, b); chk("R1 chan", 16'(b), 16'h00);
    rd(2'd2, b); chk("R1 window", 16'(b), 16'h00);

    for (int i = 0; i < 6; i++) begin
      strobe(int'(VEC[i][31:28]), int'(VEC[i][27:16]));
      snap_ch(int'(VEC[i][31:28]));
      read16(int'(VEC[i][31:28]), v);
      chk($sformatf("R2 R5 R6 vector %0d", i), v, VEC[i][15:0]);
    end

    // R11 readback and address map
    wr(2'd0, 8'hE0); rd(2'd0, b); chk("R11 ctrl spare bits", 16'(b), 16'hE0);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFA); rd(2'd1, b); chk("R11 chan width", 16'(b), 16'h0A);
    rd(2'd3, b); chk("R11 addr3", 16'(b), 16'h00);
    wr(2'd2, 8'h55); wr(2'd3, 8'h55);
    read16(9, v); chk("R11 ignored writes", v, 16'h012C);

    // R4 global copy, edge only
    strobe(3, 10);
    read16(3, v); chk("R4 hold kept", v, 16'h00FF);
    wr(2'd0, 8'h08);
    wr(2'd0, 8'h08);
    strobe(3, 5);
    wr(2'd0, 8'h08);
    read16(3, v); chk("R4 single copy", v, 16'h0109);
    read16(5, v); chk("R4 idle channel", v, 16'h0000);

    // R12 reads without effect
    repeat (5) begin rd(2'd2, b); rd(2'd0, b); end
    snap_ch(3); read16(3, v); chk("R12 no side effect", v, 16'h010E);

    // R7 short pulse
    wr(2'd0, 8'h10); wr(2'd0, 8'h00);
    snap_ch(3); read16(3, v); chk("R7 short pulse", v, 16'h010E);

    // R7 long hold with R9 competing strobe
    @(negedge clk); viol[7] = 1'b1;
    wr(2'd0, 8'h10);
    repeat (CLR + 10) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h00; viol[7] = 1'b0;
    @(negedge clk); reg_wr = 1'b0;
    wr(2'd0, 8'h08); wr(2'd0, 8'h00);
    read16(3, v);  chk("R7 clear ch3", v, 16'h0000);
    read16(13, v); chk("R7 clear ch13", v, 16'h0000);
    read16(7, v);  chk("R9 clear beats strobe", v, 16'h0000);

    // R8 per-channel clear
    strobe(1, 20); strobe(2, 30);
    wr(2'd1, 8'd2); wr(2'd0, 8'h01);
    repeat (CLR + 5) @(negedge clk);
    wr(2'd0, 8'h00);
    snap_ch(2); read16(2, v); chk("R8 selected cleared", v, 16'h0000);
    snap_ch(1); read16(1, v); chk("R8 other kept", v, 16'h0014);

    // R10 no-channel selections
    strobe(1, 5);
    snap_ch(14);
    wr(2'd1, 8'd14); rd(2'd2, b); chk("R10 low byte", 16'(b), 16'h00);
    wr(2'd0, 8'h04); rd(2'd2, b); chk("R10 high byte", 16'(b), 16'h00);
    wr(2'd0, 8'h00);
    read16(1, v); chk("R10 copy hits none", v, 16'h0014);
    wr(2'd1, 8'd15); wr(2'd0, 8'h01);
    repeat (CLR + 5) @(negedge clk);
    wr(2'd0, 8'h00);
    snap_ch(1); read16(1, v); chk("R10 clear hits none", v, 16'h0019);

    // R3 saturation
    strobe(4, 65540);
    snap_ch(4); read16(4, v); chk("R3 saturate", v, 16'hFFFF);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule